// File: doc/BRIEF.md
# BCD Nine's Complementer with Gating

This block takes a single decimal digit in 8-4-2-1 binary-coded form and returns either the digit itself, its nine's complement, or an all-zero digit. It is meant to sit in front of a decimal adder. There, the complement request acts as the add/subtract select, so subtraction becomes the addition of the nine's complement plus a carry-in.

A second control, the complement inhibit, can block the complement request. This lets the request be gated by other logic, or driven from an inverted source. A zero override has the highest priority and clears the digit. The six codes above nine are not valid decimal digits, but they still get fixed results in complement mode. Those results come from the same four bit equations that handle the legal digits.

A parameter picks one of two output styles. One is purely combinational. The other registers the result once, with an asynchronous active-low reset, so the digit can be checked cycle by cycle.

Top module: `nines_comp_gate`

## Requirements
- R1: The input and output digits are 4 bits wide with 8-4-2-1 weighting. Bit 0 has weight 1 and bit 3 has weight 8.
- R2: When `cmp_req` is 0 and `force_zero` is 0, `digit_out` equals `digit_in`, whatever the value of `cmp_inhibit`.
- R3: When `cmp_req` is 1, `cmp_inhibit` is 0 and `force_zero` is 0, a legal input 0 to 9 gives the output 9 minus the input.
- R4: When `force_zero` is 1, `digit_out` is 0000, whatever the values of all other inputs.
- R5: In complement mode, each output bit follows these equations. Output bit 0 is the inverse of input bit 0. Output bit 1 equals input bit 1. Output bit 2 is input bit 1 XOR input bit 2. Output bit 3 is 1 only when input bits 1, 2 and 3 are all 0.
- R6: When `cmp_req` and `cmp_inhibit` are both 1 and `force_zero` is 0, `digit_out` equals `digit_in`.
- R7: In complement mode, the illegal inputs 10, 11, 12, 13, 14 and 15 give the outputs 7, 6, 5, 4, 3 and 2.
- R8: With `REGISTERED`=1, `digit_out` takes the result of the inputs sampled at a rising clock edge, and holds it until the next rising edge. While `rst_n` is 0, `digit_out` is 0000. With `REGISTERED`=0, the output follows the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| digit_in | input | 4 | BCD digit, bit 0 least significant |
| cmp_req | input | 1 | Requests the nine's complement |
| cmp_inhibit | input | 1 | Active-high block of the complement request |
| force_zero | input | 1 | Forces the output to zero, highest priority |
| digit_out | output | 4 | Resulting digit |

## Verification
On every clock edge, the assertions check the zero override and both pass-through cases (request low, and request blocked by the inhibit). They also check that a legal digit and its complement sum to nine, that bit 0 is inverted in complement mode, and that the illegal codes map to seventeen minus the input. Some behaviour only the bench's scenarios can show. These are the register's one-edge latency and hold between edges, and the clearing by reset while the inputs are nonzero. A full sweep of all sixteen codes under all eight control combinations checks each result against an independent arithmetic model.

// File: rtl/ncg_pkg.sv
package ncg_pkg;
  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_CMP  = 2'd1,
    MODE_ZERO = 2'd2
  } ncg_mode_e;
endpackage

// File: rtl/ncg_mode_dec.sv
module ncg_mode_dec
  import ncg_pkg::*;
(
  input  logic      cmp_req,
  input  logic      cmp_inhibit,
  input  logic      force_zero,
  output ncg_mode_e mode
);
  // Priority: zero override, then gated complement, else pass-through.
  always_comb begin
    if (force_zero)
      mode = MODE_ZERO;
    else if (cmp_req && !cmp_inhibit)
      mode = MODE_CMP;
    else
      mode = MODE_PASS;
  end
endmodule

// File: rtl/ncg_cmp_core.sv
module ncg_cmp_core
  import ncg_pkg::*;
(
  input  digit_t    d,
  input  ncg_mode_e mode,
  output digit_t    y
);
  digit_t cmp_val;

  // Four bit equations; they also define results for codes 10..15.
  always_comb begin
    cmp_val[0] = ~d[0];
    cmp_val[1] =  d[1];
    cmp_val[2] =  d[1] ^ d[2];
    cmp_val[3] = ~(d[1] | d[2] | d[3]);
  end

  always_comb begin
    unique case (mode)
      MODE_CMP:  y = cmp_val;
      MODE_ZERO: y = '0;
      default:   y = d;
    endcase
  end
endmodule

// File: rtl/ncg_out_stage.sv
module ncg_out_stage
  import ncg_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  digit_t d_next,
  output digit_t q
);
  generate
    if (REGISTERED) begin : g_reg
      digit_t q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q_r <= '0;
        else
          q_r <= d_next;
      end
      assign q = q_r;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d_next;
    end
  endgenerate
endmodule

// File: rtl/nines_comp_gate.sv
module nines_comp_gate
  import ncg_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] digit_in,
  input  logic       cmp_req,
  input  logic       cmp_inhibit,
  input  logic       force_zero,
  output logic [3:0] digit_out
);
  ncg_mode_e mode;
  digit_t    result;

  ncg_mode_dec u_dec (
    .cmp_req    (cmp_req),
    .cmp_inhibit(cmp_inhibit),
    .force_zero (force_zero),
    .mode       (mode)
  );

  ncg_cmp_core u_core (
    .d   (digit_in),
    .mode(mode),
    .y   (result)
  );

  ncg_out_stage #(.REGISTERED(REGISTERED)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_next(result),
    .q     (digit_out)
  );

  logic in_cmp;
  assign in_cmp = cmp_req && !cmp_inhibit && !force_zero;

  generate
    if (REGISTERED) begin : g_chk_reg
      AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |=> digit_out == 4'd0); // R4
      AST_PASS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_req && !force_zero) |=> digit_out == $past(digit_in)); // R2
      AST_PASS_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_inhibit && !force_zero) |=> digit_out == $past(digit_in)); // R6
      AST_CMP_SUM_NINE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmp && digit_in <= 4'd9) |=> (digit_out + $past(digit_in)) == 4'd9); // R3
      AST_CMP_BIT0_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        in_cmp |=> digit_out[0] != $past(digit_in[0])); // R5
      AST_ILLEGAL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmp && digit_in >= 4'd10) |=> (digit_out + $past(digit_in)) == 5'd17); // R7
    end else begin : g_chk_comb
      AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |-> digit_out == 4'd0); // R4
      AST_PASS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_req && !force_zero) |-> digit_out == digit_in); // R2
      AST_PASS_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_inhibit && !force_zero) |-> digit_out == digit_in); // R6
      AST_CMP_SUM_NINE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmp && digit_in <= 4'd9) |-> (digit_out + digit_in) == 4'd9); // R3
      AST_CMP_BIT0_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        in_cmp |-> digit_out[0] != digit_in[0]); // R5
      AST_ILLEGAL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmp && digit_in >= 4'd10) |-> (digit_out + digit_in) == 5'd17); // R7
    end
  endgenerate
endmodule

// File: tb/nines_comp_gate_test.sv
module nines_comp_gate_test;
  localparam bit REG = 1'b1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] digit_in;
  logic       cmp_req, cmp_inhibit, force_zero;
  logic [3:0] digit_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  nines_comp_gate #(.REGISTERED(REG)) uut (
    .clk(clk), .rst_n(rst_n), .digit_in(digit_in), .cmp_req(cmp_req),
    .cmp_inhibit(cmp_inhibit), .force_zero(force_zero), .digit_out(digit_out)
  );

  function automatic logic [3:0] ref_model(input logic [3:0] d, input logic c,
                                           input logic inh, input logic z);
    int v;
    if (z) return 4'd0;
    if (c && !inh) begin
      v = (d <= 9) ? 9 - int'(d) : 17 - int'(d);
      return 4'(v);
    end
    return d;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge; the result is visible one rising edge later.
  task automatic apply(input logic [3:0] d, input logic c, input logic inh, input logic z);
    @(negedge clk);
    digit_in = d; cmp_req = c; cmp_inhibit = inh; force_zero = z;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    digit_in = 4'd6; cmp_req = 1'b0; cmp_inhibit = 1'b0; force_zero = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset clears output", digit_out, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 first value after reset", digit_out, 4'd6);
  endtask

  task automatic t_pass();
    apply(4'd5, 1'b0, 1'b0, 1'b0); check("R2 pass inhibit low", digit_out, 4'd5);
    apply(4'd9, 1'b0, 1'b1, 1'b0); check("R2 pass inhibit high", digit_out, 4'd9);
    apply(4'd8, 1'b0, 1'b0, 1'b0); check("R1 weight-8 bit alone", digit_out, 4'b1000);
  endtask

  task automatic t_complement();
    apply(4'd0, 1'b1, 1'b0, 1'b0); check("R3 comp of 0", digit_out, 4'd9);
    apply(4'd9, 1'b1, 1'b0, 1'b0); check("R3 comp of 9", digit_out, 4'd0);
    apply(4'd3, 1'b1, 1'b0, 1'b0); check("R3 comp of 3", digit_out, 4'd6);
    apply(4'b0110, 1'b1, 1'b0, 1'b0);
    check("R5 bit equations on 0110", digit_out, 4'b0011);
    apply(4'b0001, 1'b1, 1'b0, 1'b0);
    check("R5 bit3 set when bits 1..3 low", digit_out, 4'b1000);
  endtask

  task automatic t_illegal();
    for (int k = 10; k < 16; k++) begin
      apply(4'(k), 1'b1, 1'b0, 1'b0);
      check($sformatf("R7 illegal code %0d", k), digit_out, 4'(17 - k));
    end
  endtask

  task automatic t_inhibit();
    apply(4'd2, 1'b1, 1'b1, 1'b0); check("R6 inhibited request passes 2", digit_out, 4'd2);
    apply(4'd13, 1'b1, 1'b1, 1'b0); check("R6 inhibited request passes 13", digit_out, 4'd13);
  endtask

  task automatic t_zero();
    apply(4'd7, 1'b0, 1'b0, 1'b1); check("R4 zero over pass", digit_out, 4'd0);
    apply(4'd4, 1'b1, 1'b0, 1'b1); check("R4 zero over complement", digit_out, 4'd0);
    apply(4'd15, 1'b1, 1'b1, 1'b1); check("R4 zero over inhibit", digit_out, 4'd0);
  endtask

  task automatic t_latency();
    apply(4'd1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    digit_in = 4'd2; cmp_req = 1'b1;
    #1;
    check("R8 holds until rising edge", digit_out, 4'd1);
    @(negedge clk);
    check("R8 updates after rising edge", digit_out, 4'd7);
  endtask

  task automatic t_sweep();
    for (int ctl = 0; ctl < 8; ctl++) begin
      for (int d = 0; d < 16; d++) begin
        apply(4'(d), ctl[0], ctl[1], ctl[2]);
        check($sformatf("R2/R3/R4/R6/R7 sweep d=%0d ctl=%0d", d, ctl), digit_out,
              ref_model(4'(d), ctl[0], ctl[1], ctl[2]));
      end
    end
  endtask

  initial begin
    t_reset();
    t_pass();
    t_complement();
    t_illegal();
    t_inhibit();
    t_zero();
    if (REG) t_latency();
    t_sweep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule